// File: doc/BRIEF.md
# Counted-Assertion Interrupt Dispatcher

This block turns interrupt requests from a set of input pins into interrupt messages. Each pin has an up/down counter instead of a sampled wire level. An assert request adds one to the counter and a deassert request takes one away. A pulse request does both in the same cycle. A pin tries to deliver only when its counter goes from zero to one. Every pin also has a 64-bit routing entry that holds the vector, the destination, the delivery mode, the trigger mode and a mask bit.

For level-triggered pins, an in-service bit in the entry blocks further deliveries. An end-of-interrupt broadcast carries a vector. It is handled by a scan that visits one pin per cycle, and the block stays busy for the whole scan. At each matching pin the scan clears the in-service bit, and the pin delivers again if its counter is still above zero. A write to a routing entry through the side port can also start a delivery attempt.

Messages go out one at a time on a valid/ready interface. When several pins are pending, the lowest pin number is sent first. A pin that loses arbitration stays pending until it is served.

Top module: `irq_count_dispatch`

## Requirements
- R1: `req_op` encodes 01 = assert (count +1), 10 = deassert (count −1), 11 = pulse (assert then deassert in one cycle) and 00 = no request. A request is taken in a cycle where `req_valid` is high and `busy` is low. A pulse on an edge pin whose count is zero produces one message, and the count returns to zero.
- R2: A delivery attempt from a request happens only when the count goes from 0 to 1. Any other count change produces no message.
- R3: `cnt_err` is high for exactly the one cycle after a request is taken, in two cases. The first is a deassert step that leaves the count negative. The second is an assert on a count at its top value (2^(CNT_W−1)−1), where the count saturates. Every other taken request leaves `cnt_err` low.
- R4: An attempt on an entry with bit 16 (mask) set produces no message and leaves bit 14 (in-service) clear.
- R5: Bit 15 selects level trigger. On a level entry, an attempt is dropped while bit 14 is set. Otherwise the attempt sets bit 14 and sends the message. Edge entries send the message on every attempt and never set bit 14.
- R6: A message carries the pin number, the vector from bits 7:0, the destination from bits 63:56, the delivery mode from bits 10:8, the logical-destination flag from bit 11 and the level flag from bit 15.
- R7: An EOI is taken when `eoi_valid` is high and `busy` is low. `busy` is then high for exactly NUM_PINS cycles. Each pin whose bit 14 is set and whose vector equals the EOI vector gets bit 14 cleared. If that pin's count is above zero it makes a new attempt. Non-matching pins are left unchanged.
- R8: An entry write through the side port stores the written data, with three exceptions: bit 14 keeps its stored value, bit 12 reads as 0, and bit 14 is cleared if the new entry is edge-triggered. After the write, a level entry whose count is above zero makes an attempt.
- R9: When several pins are pending, messages leave in ascending pin order. Pending pins wait until they are served.
- R10: After reset every entry reads 64'h0000_0000_0001_0000 (masked, edge), all counts are zero, and `out_valid`, `busy` and `cnt_err` are low. A message held with `out_ready` low keeps its fields unchanged.
- R11: While `busy` is high, pin requests and entry writes are held off and have no effect. A request held until `busy` falls is then applied normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pin request present |
| req_pin | input | clog2(NUM_PINS) | Pin of the request |
| req_op | input | 2 | Request kind (01 assert, 10 deassert, 11 pulse) |
| busy | output | 1 | EOI scan in progress; requests, writes and EOIs held off |
| cnt_err | output | 1 | Count went negative or saturated on the last taken request |
| tbl_wr_en | input | 1 | Routing entry write |
| tbl_wr_pin | input | clog2(NUM_PINS) | Entry written |
| tbl_wr_data | input | 64 | Entry data |
| tbl_rd_pin | input | clog2(NUM_PINS) | Entry read |
| tbl_rd_data | output | 64 | Current entry contents (combinational) |
| eoi_valid | input | 1 | End-of-interrupt broadcast |
| eoi_vector | input | 8 | Vector of the EOI |
| out_valid | output | 1 | Message available |
| out_ready | input | 1 | Consumer takes the message |
| out_pin | output | clog2(NUM_PINS) | Source pin |
| out_vector | output | 8 | Vector |
| out_dest | output | 8 | Destination |
| out_dmode | output | 3 | Delivery mode |
| out_logical | output | 1 | Logical destination flag |
| out_level | output | 1 | Level-trigger flag |

## Verification
Counts and in-service bits are hidden state, and they show up at the ports mainly as messages that go missing or appear when they should not. A count that drifts by one either suppresses the next delivery on a 0-to-1 change or adds an extra one. The bench checks every message against a scoreboard and flags any message it did not expect. A wrong in-service bit can be read back through the side port right after the request, write or EOI scan that changed it. A scan that is too long or too short shows directly in the number of cycles `busy` stays high. Arbitration faults show up as the wrong message order while the output is stalled.

// File: rtl/irq_cd_pkg.sv
package irq_cd_pkg;

  localparam int ENT_W    = 64;
  localparam int VEC_W    = 8;
  localparam int DEST_W   = 8;
  localparam int DEST_LO  = ENT_W - DEST_W;
  localparam int DMODE_W  = 3;
  localparam int DMODE_LO = 8;

  localparam int B_LOGICAL = 11;
  localparam int B_STATUS  = 12;
  localparam int B_RIRR    = 14;
  localparam int B_LEVEL   = 15;
  localparam int B_MASK    = 16;

  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_ASSERT   = 2'b01,
    OP_DEASSERT = 2'b10,
    OP_PULSE    = 2'b11
  } pin_op_e;

  // Entry write: status bit reads zero, in-service bit is kept from the old entry.
  function automatic logic [ENT_W-1:0] merge_write(input logic [ENT_W-1:0] old_e,
                                                   input logic [ENT_W-1:0] wd);
    logic [ENT_W-1:0] r;
    r           = wd;
    r[B_STATUS] = 1'b0;
    r[B_RIRR]   = old_e[B_RIRR];
    return r;
  endfunction

endpackage

// File: rtl/irq_cd_pin_slot.sv
module irq_cd_pin_slot
  import irq_cd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_hit,
  input  logic [1:0]       req_op,
  input  logic             wr_hit,
  input  logic [ENT_W-1:0] wr_data,
  input  logic             scan_hit,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             take,
  output logic [ENT_W-1:0] entry,
  output logic             pending,
  output logic             cnt_err
);

  localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic signed [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef struct packed {
    logic signed [CNT_W-1:0] cnt;
    logic                    err;
    logic                    fire;
  } step_t;

  function automatic step_t count_up(input logic signed [CNT_W-1:0] c);
    step_t s;
    s.fire = (c == '0);
    if (c == CNT_MAX) begin
      s.cnt = c;
      s.err = 1'b1;
    end else begin
      s.cnt = c + CNT_ONE;
      s.err = 1'b0;
    end
    return s;
  endfunction

  function automatic step_t count_down(input logic signed [CNT_W-1:0] c);
    step_t s;
    s.fire = 1'b0;
    if (c == CNT_MIN) begin
      s.cnt = c;
      s.err = 1'b1;
    end else begin
      s.cnt = c - CNT_ONE;
      s.err = s.cnt[CNT_W-1];
    end
    return s;
  endfunction

  function automatic step_t apply_op(input logic signed [CNT_W-1:0] c, input logic [1:0] op);
    step_t a;
    step_t b;
    case (op)
      OP_ASSERT:   a = count_up(c);
      OP_DEASSERT: a = count_down(c);
      OP_PULSE: begin
        b     = count_up(c);
        a     = count_down(b.cnt);
        a.err = a.err | b.err;
        a.fire = b.fire;
      end
      default: begin
        a.cnt  = c;
        a.err  = 1'b0;
        a.fire = 1'b0;
      end
    endcase
    return a;
  endfunction

  function automatic logic is_positive(input logic signed [CNT_W-1:0] c);
    return !c[CNT_W-1] && (c != '0);
  endfunction

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic [ENT_W-1:0]        ent_q, ent_d;
  logic                    pend_q, pend_d;
  step_t                   st;
  logic                    eoi_match;
  logic                    attempt;
  logic                    deliver;

  always_comb begin
    st    = apply_op(cnt_q, req_hit ? req_op : OP_NONE);
    cnt_d = st.cnt;
    ent_d = ent_q;
    if (wr_hit) ent_d = merge_write(ent_q, wr_data);
    if (!ent_d[B_LEVEL]) ent_d[B_RIRR] = 1'b0;
    eoi_match = scan_hit && ent_d[B_RIRR] && (ent_d[VEC_W-1:0] == eoi_vec);
    if (eoi_match) ent_d[B_RIRR] = 1'b0;
    attempt = st.fire
            | (wr_hit && ent_d[B_LEVEL] && is_positive(cnt_d))
            | (eoi_match && is_positive(cnt_d));
    deliver = attempt && !ent_d[B_MASK] && !(ent_d[B_LEVEL] && ent_d[B_RIRR]);
    if (deliver && ent_d[B_LEVEL]) ent_d[B_RIRR] = 1'b1;
    pend_d = deliver | (pend_q & ~take);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ent_q  <= ENT_RESET;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ent_q  <= ent_d;
      pend_q <= pend_d;
    end
  end

  assign entry   = ent_q;
  assign pending = pend_q;
  assign cnt_err = req_hit && st.err;

endmodule

// File: rtl/irq_cd_pick.sv
module irq_cd_pick #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign onehot = req & (~req + {{(N-1){1'b0}}, 1'b1});
  assign any    = |req;

endmodule

// File: rtl/irq_cd_eoi_scan.sv
module irq_cd_eoi_scan
  import irq_cd_pkg::*;
#(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             busy,
  output logic [IW-1:0]    scan_idx,
  output logic [VEC_W-1:0] scan_vec
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      scan_idx <= '0;
      scan_vec <= '0;
    end else if (!active_q) begin
      if (eoi_valid) begin
        active_q <= 1'b1;
        scan_idx <= '0;
        scan_vec <= eoi_vector;
      end
    end else begin
      scan_idx <= scan_idx + 1'b1;
      if (scan_idx == LAST) active_q <= 1'b0;
    end
  end

  assign busy = active_q;

endmodule

// File: rtl/irq_count_dispatch.sv
module irq_count_dispatch
  import irq_cd_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [$clog2(NUM_PINS)-1:0] req_pin,
  input  logic [1:0]                  req_op,
  output logic                        busy,
  output logic                        cnt_err,
  input  logic                        tbl_wr_en,
  input  logic [$clog2(NUM_PINS)-1:0] tbl_wr_pin,
  input  logic [63:0]                 tbl_wr_data,
  input  logic [$clog2(NUM_PINS)-1:0] tbl_rd_pin,
  output logic [63:0]                 tbl_rd_data,
  input  logic                        eoi_valid,
  input  logic [7:0]                  eoi_vector,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [$clog2(NUM_PINS)-1:0] out_pin,
  output logic [7:0]                  out_vector,
  output logic [7:0]                  out_dest,
  output logic [2:0]                  out_dmode,
  output logic                        out_logical,
  output logic                        out_level
);

  localparam int PIN_W = $clog2(NUM_PINS);

  logic                 req_fire;
  logic                 wr_fire;
  logic [PIN_W-1:0]     scan_idx;
  logic [VEC_W-1:0]     scan_vec;
  logic [ENT_W-1:0]     ent_all [NUM_PINS];
  logic [NUM_PINS-1:0]  pending_vec;
  logic [NUM_PINS-1:0]  irr_vec;
  logic [NUM_PINS-1:0]  level_vec;
  logic [NUM_PINS-1:0]  err_vec;
  logic [NUM_PINS-1:0]  take_vec;
  logic [NUM_PINS-1:0]  pick_oh;
  logic [PIN_W-1:0]     pick_idx;
  logic                 any_pend;
  logic                 load;
  logic [ENT_W-1:0]     sel_ent;

  assign req_fire = req_valid && !busy && (req_op != OP_NONE);
  assign wr_fire  = tbl_wr_en && !busy;

  irq_cd_eoi_scan #(.N(NUM_PINS)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoi_valid (eoi_valid),
    .eoi_vector(eoi_vector),
    .busy      (busy),
    .scan_idx  (scan_idx),
    .scan_vec  (scan_vec)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_cd_pin_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_hit (req_fire && (req_pin == PIN_W'(g))),
      .req_op  (req_op),
      .wr_hit  (wr_fire && (tbl_wr_pin == PIN_W'(g))),
      .wr_data (tbl_wr_data),
      .scan_hit(busy && (scan_idx == PIN_W'(g))),
      .eoi_vec (scan_vec),
      .take    (take_vec[g]),
      .entry   (ent_all[g]),
      .pending (pending_vec[g]),
      .cnt_err (err_vec[g])
    );
    assign irr_vec[g]   = ent_all[g][B_RIRR];
    assign level_vec[g] = ent_all[g][B_LEVEL];
  end

  irq_cd_pick #(.N(NUM_PINS)) u_pick (
    .req   (pending_vec),
    .any   (any_pend),
    .idx   (pick_idx),
    .onehot(pick_oh)
  );

  assign load     = any_pend && (!out_valid || out_ready);
  assign take_vec = load ? pick_oh : '0;
  assign sel_ent  = ent_all[pick_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_pin     <= '0;
      out_vector  <= '0;
      out_dest    <= '0;
      out_dmode   <= '0;
      out_logical <= 1'b0;
      out_level   <= 1'b0;
      cnt_err     <= 1'b0;
    end else begin
      cnt_err <= |err_vec;
      if (load) begin
        out_valid   <= 1'b1;
        out_pin     <= pick_idx;
        out_vector  <= sel_ent[VEC_W-1:0];
        out_dest    <= sel_ent[DEST_LO +: DEST_W];
        out_dmode   <= sel_ent[DMODE_LO +: DMODE_W];
        out_logical <= sel_ent[B_LOGICAL];
        out_level   <= sel_ent[B_LEVEL];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign tbl_rd_data = ent_all[tbl_rd_pin];

endmodule

// File: rtl/irq_cd_checker.sv
module irq_cd_checker #(
  parameter int NUM_PINS = 32,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          req_op,
  input logic                busy,
  input logic                cnt_err,
  input logic                eoi_valid,
  input logic                out_valid,
  input logic                out_ready,
  input logic [PIN_W-1:0]    out_pin,
  input logic [7:0]          out_vector,
  input logic [7:0]          out_dest,
  input logic [NUM_PINS-1:0] pending_vec,
  input logic [NUM_PINS-1:0] irr_vec,
  input logic [NUM_PINS-1:0] level_vec
);

  logic [15:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_run <= '0;
    else                 busy_run <= busy_run + 16'd1;
  end

  // R5 / R8: in-service only ever marks level entries
  p_irr_level_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_vec & ~level_vec) == '0);

  // R10: stalled message keeps its fields
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pin) &&
                                   $stable(out_vector) && $stable(out_dest)));

  // R7: a taken EOI starts the scan
  p_busy_after_eoi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !busy) |=> busy);

  // R7: scan lasts exactly NUM_PINS cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 16'(NUM_PINS)));

  // R3: error flag only follows a taken request
  p_err_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_err |-> $past(req_valid && !busy && (req_op != 2'b00)));

  // R9: a new message comes from a pending pin
  p_valid_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(pending_vec != '0));

  // R9: pending pins keep the output busy after a handshake
  p_pending_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (pending_vec != '0)) |=> out_valid);

endmodule

bind irq_count_dispatch irq_cd_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .busy       (busy),
  .cnt_err    (cnt_err),
  .eoi_valid  (eoi_valid),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pin    (out_pin),
  .out_vector (out_vector),
  .out_dest   (out_dest),
  .pending_vec(pending_vec),
  .irr_vec    (irr_vec),
  .level_vec  (level_vec)
);

// File: tb/irq_count_dispatch_tb.sv
module irq_count_dispatch_tb;

  localparam int NP = 32;
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [PW-1:0] req_pin = '0;
  logic [1:0]    req_op = 2'b00;
  logic          busy;
  logic          cnt_err;
  logic          tbl_wr_en = 1'b0;
  logic [PW-1:0] tbl_wr_pin = '0;
  logic [63:0]   tbl_wr_data = '0;
  logic [PW-1:0] tbl_rd_pin = '0;
  logic [63:0]   tbl_rd_data;
  logic          eoi_valid = 1'b0;
  logic [7:0]    eoi_vector = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_pin;
  logic [7:0]    out_vector;
  logic [7:0]    out_dest;
  logic [2:0]    out_dmode;
  logic          out_logical;
  logic          out_level;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    pin;
    int    vec;
    int    dest;
    int    dmode;
    int    logical;
    int    level;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  irq_count_dispatch #(.NUM_PINS(NP), .CNT_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin), .req_op(req_op),
    .busy(busy), .cnt_err(cnt_err), .tbl_wr_en(tbl_wr_en), .tbl_wr_pin(tbl_wr_pin),
    .tbl_wr_data(tbl_wr_data), .tbl_rd_pin(tbl_rd_pin), .tbl_rd_data(tbl_rd_data),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .out_valid(out_valid),
    .out_ready(out_ready), .out_pin(out_pin), .out_vector(out_vector), .out_dest(out_dest),
    .out_dmode(out_dmode), .out_logical(out_logical), .out_level(out_level)
  );

  // Monitor: every handshake is compared with the next expected message
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected message pin=%0d vec=%0h, expected none", out_pin, out_vector);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (int'(out_pin) != e.pin || int'(out_vector) != e.vec || int'(out_dest) != e.dest ||
            int'(out_dmode) != e.dmode || int'(out_logical) != e.logical ||
            int'(out_level) != e.level) begin
          errors++;
          $display("FAIL %s message got pin=%0d vec=%0h dest=%0h dm=%0d lg=%0d lv=%0d expected pin=%0d vec=%0h dest=%0h dm=%0d lg=%0d lv=%0d",
                   e.tag, out_pin, out_vector, out_dest, out_dmode, out_logical, out_level,
                   e.pin, e.vec, e.dest, e.dmode, e.logical, e.level);
        end
      end
    end
  end

  function automatic logic [63:0] mk(input int vec, input int dm, input int lg,
                                     input int lv, input int mask, input int dest);
    logic [63:0] r;
    r        = '0;
    r[7:0]   = vec[7:0];
    r[10:8]  = dm[2:0];
    r[11]    = lg[0];
    r[15]    = lv[0];
    r[16]    = mask[0];
    r[63:56] = dest[7:0];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic expect_msg(input int pin, input logic [63:0] e, input string tag);
    exp_t x;
    x.pin = pin; x.vec = int'(e[7:0]); x.dest = int'(e[63:56]); x.dmode = int'(e[10:8]);
    x.logical = int'(e[11]); x.level = int'(e[15]); x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic wait_req_accept();
    bit taken;
    taken = 1'b0;
    while (!taken) begin
      taken = !busy;
      tick();
    end
    req_valid = 1'b0;
  endtask

  task automatic req(input int pin, input logic [1:0] op);
    req_valid = 1'b1; req_pin = PW'(pin); req_op = op;
    wait_req_accept();
  endtask

  task automatic wr(input int pin, input logic [63:0] d);
    bit taken;
    tbl_wr_en = 1'b1; tbl_wr_pin = PW'(pin); tbl_wr_data = d;
    taken = 1'b0;
    while (!taken) begin
      taken = !busy;
      tick();
    end
    tbl_wr_en = 1'b0;
  endtask

  task automatic eoi(input int vec);
    bit taken;
    eoi_valid = 1'b1; eoi_vector = vec[7:0];
    taken = 1'b0;
    while (!taken) begin
      taken = !busy;
      tick();
    end
    eoi_valid = 1'b0;
  endtask

  task automatic busy_len(input string tag);
    int n;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      tick();
    end
    chk(tag, 64'(n), 64'(NP));
  endtask

  task automatic rd(input int pin, output logic [63:0] d);
    tbl_rd_pin = PW'(pin);
    #1;
    d = tbl_rd_data;
  endtask

  task automatic drain(input string tag);
    repeat (4) tick();
    chk(tag, {32'(exp_q.size()), 31'd0, out_valid}, 64'd0);
  endtask

  localparam logic [1:0] A = 2'b01;
  localparam logic [1:0] D = 2'b10;
  localparam logic [1:0] P = 2'b11;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] e3, e5, e7m, e7, e7e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R10 reset state
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 busy", 64'(busy), 64'd0);
    chk("R10 cnt_err", 64'(cnt_err), 64'd0);
    rd(0, d);  chk("R10 entry0", d, 64'h0000_0000_0001_0000);
    rd(31, d); chk("R10 entry31", d, 64'h0000_0000_0001_0000);

    // R2 / R6 edge pin 3
    e3 = mk(8'h41, 0, 0, 0, 0, 8'h12);
    wr(3, e3);
    rd(3, d); chk("R8 readback pin3", d, e3);
    expect_msg(3, e3, "R6");
    req(3, A);
    drain("R6 delivered");
    req(3, A);
    req(3, D);
    req(3, D);
    drain("R2 no delivery on other changes");

    // R1 pulses on edge pin
    expect_msg(3, e3, "R1");
    req(3, P);
    drain("R1 pulse one");
    expect_msg(3, e3, "R1");
    req(3, P);
    drain("R1 pulse two");

    // R3 negative count and saturation on pin 5
    e5 = mk(8'h66, 5, 1, 0, 0, 8'hA5);
    wr(5, e5);
    req(5, D);
    chk("R3 negative flag", 64'(cnt_err), 64'd1);
    req(5, A);
    chk("R3 flag clears", 64'(cnt_err), 64'd0);
    drain("R2 -1 to 0 silent");
    expect_msg(5, e5, "R6");
    req(5, A);
    drain("R6 logical fields");
    for (int i = 0; i < 6; i++) req(5, A);
    chk("R3 no flag at top", 64'(cnt_err), 64'd0);
    req(5, A);
    chk("R3 saturate flag", 64'(cnt_err), 64'd1);
    for (int i = 0; i < 7; i++) req(5, D);
    chk("R3 no flag back to zero", 64'(cnt_err), 64'd0);
    drain("R3 no message while counting");
    expect_msg(5, e5, "R3");
    req(5, A);
    drain("R3 saturated count returns to zero");
    req(5, D);

    // R4 masked level pin 7
    e7m = mk(8'h50, 1, 0, 1, 1, 8'h33);
    e7  = mk(8'h50, 1, 0, 1, 0, 8'h33);
    e7e = mk(8'h50, 1, 0, 0, 0, 8'h33);
    wr(7, e7m);
    req(7, A);
    drain("R4 masked silent");
    rd(7, d); chk("R4 in-service clear", 64'(d[14]), 64'd0);
    expect_msg(7, e7, "R8");
    wr(7, e7);
    drain("R8 unmask write delivers");
    rd(7, d); chk("R5 in-service set", 64'(d[14]), 64'd1);

    // R5 suppression
    req(7, D);
    req(7, A);
    drain("R5 suppressed while in service");
    rd(7, d); chk("R5 in-service kept", 64'(d[14]), 64'd1);

    // R7 EOI
    eoi(8'h51);
    busy_len("R7 busy length");
    drain("R7 non-matching silent");
    rd(7, d); chk("R7 non-matching kept", 64'(d[14]), 64'd1);
    expect_msg(7, e7, "R7");
    eoi(8'h50);
    busy_len("R7 busy length match");
    drain("R7 redelivery");
    rd(7, d); chk("R7 set again", 64'(d[14]), 64'd1);
    req(7, D);
    eoi(8'h50);
    busy_len("R7 busy length idle");
    drain("R7 no redelivery at zero");
    rd(7, d); chk("R7 cleared", 64'(d[14]), 64'd0);

    // R8 write rules
    wr(7, e7 | 64'h0000_0000_0000_5000);
    rd(7, d); chk("R8 read-only bits", d, e7);
    drain("R8 zero count no attempt");
    expect_msg(7, e7, "R5");
    req(7, A);
    drain("R5 level delivery");
    wr(7, e7);
    rd(7, d); chk("R8 in-service preserved", 64'(d[14]), 64'd1);
    drain("R8 suppressed rewrite");
    wr(7, e7e);
    rd(7, d); chk("R8 edge clears in-service", d, e7e);
    drain("R8 edge write silent");
    expect_msg(7, e7, "R8");
    wr(7, e7);
    drain("R8 level write with count");

    // R9 / R10 arbitration while stalled
    out_ready = 1'b0;
    wr(20, mk(8'h34, 0, 0, 0, 0, 0));
    wr(9,  mk(8'h29, 0, 0, 0, 0, 0));
    wr(12, mk(8'h2C, 0, 0, 0, 0, 0));
    expect_msg(20, mk(8'h34, 0, 0, 0, 0, 0), "R9");
    expect_msg(9,  mk(8'h29, 0, 0, 0, 0, 0), "R9");
    expect_msg(12, mk(8'h2C, 0, 0, 0, 0, 0), "R9");
    req(20, A);
    req(12, A);
    req(9, A);
    repeat (3) tick();
    chk("R10 held pin", {63'd0, out_valid} | (64'(out_pin) << 8), 64'd1 | (64'd20 << 8));
    repeat (5) tick();
    chk("R10 held vector", 64'(out_vector), 64'h34);
    out_ready = 1'b1;
    drain("R9 order drained");

    // R11 hold-off during scan
    eoi(8'hEE);
    expect_msg(3, e3, "R11");
    req_valid = 1'b1; req_pin = PW'(3); req_op = A;
    repeat (5) tick();
    chk("R11 held off", {62'd0, busy, out_valid}, 64'd2);
    wait_req_accept();
    drain("R11 applied after scan");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule